// File: doc/BRIEF.md
# Shared-Register Interrupt Aggregator

This block gathers a small group of event inputs into one interrupt line for a parent controller. Software sees a single 32-bit register. The low half holds one enable bit per source. The high half holds one sticky pending bit per source, and each pending bit sits exactly 16 places above its enable. A pending bit is captured whenever its source input is high at a clock edge, whether or not the source is enabled. Software clears a pending bit by writing a one to it.

Because the enables and the write-one-to-clear flags share one word, software changes enables by writing zeros across the high half, and acknowledges one event by writing a one to that event's pending bit only. Two parameters place the implemented sources: the bit index of the first source and the number of sources. Every other bit position reads as zero and ignores writes. Byte enables qualify each write.

Top module: `evt_aggr`

## Requirements
- R1: After reset every enable bit and every pending bit is zero, and `irq_o` is low.
- R2: For an implemented source at window bit k, a write with `wr_i` high and byte enable set for bit k loads bit k of the write data into enable k. The update shows on `rdata_o` in the cycle after the write.
- R3: If source input i is high at a clock edge, pending bit (base+i)+16 is set after that edge. This happens whatever the state of its enable.
- R4: A pending bit stays set until it is cleared. A write that carries a 1 at bit (k+16), with that byte enabled, clears pending bit k. A 0 written there leaves the bit unchanged.
- R5: A write that carries 1 at a pending bit while the matching source input is high in the same cycle leaves that pending bit set.
- R6: `irq_o` is high exactly when some pending bit and its matching enable bit are both set. It is derived combinationally from the register state.
- R7: Bit positions outside the implemented enable window [base, base+count) and outside the pending window [base+16, base+count+16) always read as zero, whatever is written to them.
- R8: A write whose byte enable is clear for a byte changes no enable bit and no pending bit in that byte.
- R9: A write that sets all bits [31:16] to one clears every pending bit whose source input is low. A write that changes enables with zeros in [31:16] leaves every pending bit unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Single-cycle write strobe |
| wdata_i | input | 32 | Write data |
| wbe_i | input | 4 | Byte enables for the write |
| rdata_o | output | 32 | Current register value (combinational) |
| src_i | input | NSRC | Event inputs; bit i maps to window bit BASE+i |
| irq_o | output | 1 | Parent interrupt |

## Verification
Embedded assertions watch every cycle for several rules. They check that unimplemented bits stay zero, that the interrupt matches the masked pending state, that a high source always leaves its pending bit set, and that pending bits never drop without a write. They also check that nothing changes after a write with all byte enables clear. The bench scenarios cover what needs a chosen sequence: exact enable updates, acknowledging a single event, and clearing all events at once. They also check that enable-only writes keep pending events, and that a source held high during an acknowledge still wins. The bench runs random writes and source patterns against a model built from the requirements, using a non-zero base offset.

// File: rtl/evt_aggr.sv
module evt_aggr #(
  parameter int BASE = 0,
  parameter int NSRC = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [31:0]      wdata_i,
  input  logic [3:0]       wbe_i,
  output logic [31:0]      rdata_o,
  input  logic [NSRC-1:0]  src_i,
  output logic             irq_o
);
  localparam int HI = BASE + NSRC - 1;
  localparam int PSH = 16;

  logic [NSRC-1:0] en_q, pend_q;
  logic [31:0] bmask;

  assign bmask = {{8{wbe_i[3]}}, {8{wbe_i[2]}}, {8{wbe_i[1]}}, {8{wbe_i[0]}}};

  logic [NSRC-1:0] en_we, en_wd, clr_w;
  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      en_we[i] = wr_i && bmask[BASE+i];
      en_wd[i] = wdata_i[BASE+i];
      clr_w[i] = wr_i && bmask[BASE+i+PSH] && wdata_i[BASE+i+PSH];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      en_q   <= (en_q & ~en_we) | (en_wd & en_we);
      pend_q <= (pend_q & ~clr_w) | src_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[HI:BASE] = en_q;
    rdata_o[HI+PSH:BASE+PSH] = pend_q;
  end

  assign irq_o = |(en_q & pend_q);

  // R7
  outside_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~(({{(32-NSRC){1'b0}}, {NSRC{1'b1}}} << BASE) |
                 ({{(32-NSRC){1'b0}}, {NSRC{1'b1}}} << (BASE+PSH)))) == 32'h0);
  // R6
  irq_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == |(rdata_o[HI:BASE] & rdata_o[HI+PSH:BASE+PSH]));
  // R3
  src_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |src_i |=> ((rdata_o[HI+PSH:BASE+PSH] & $past(src_i)) == $past(src_i)));
  // R4
  sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ((rdata_o[HI+PSH:BASE+PSH] & $past(rdata_o[HI+PSH:BASE+PSH]))
               == $past(rdata_o[HI+PSH:BASE+PSH])));
  // R8
  no_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && wbe_i == 4'h0 && src_i == '0) |=> $stable(rdata_o));
endmodule

// File: tb/evt_aggr_bench.sv
module evt_aggr_bench;
  localparam int BASE = 4;
  localparam int NSRC = 2;
  logic clk = 0, rst_n = 0, wr = 0;
  logic [31:0] wd = 0;
  logic [3:0] be = 0;
  logic [31:0] rd;
  logic [NSRC-1:0] src = 0;
  logic irq;
  int checks = 0, errors = 0;
  logic [NSRC-1:0] m_en = 0, m_pd = 0;

  always #2.5 clk = ~clk;

  evt_aggr #(.BASE(BASE), .NSRC(NSRC)) u_evt_aggr (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wd), .wbe_i(be),
    .rdata_o(rd), .src_i(src), .irq_o(irq));

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = 0;
    for (int i = 0; i < NSRC; i++) begin
      r[BASE+i] = m_en[i];
      r[BASE+i+16] = m_pd[i];
    end
    return r;
  endfunction

  task automatic model_step();
    for (int i = 0; i < NSRC; i++) begin
      if (wr && be[(BASE+i)/8]) m_en[i] = wd[BASE+i];
      if (wr && be[(BASE+i+16)/8] && wd[BASE+i+16]) m_pd[i] = 1'b0;
      if (src[i]) m_pd[i] = 1'b1;
    end
  endtask

  task automatic check(string req);
    checks++;
    if (rd !== exp_rd()) begin
      errors++;
      $display("FAIL %s rdata act=%h exp=%h", req, rd, exp_rd());
    end
    checks++;
    if (irq !== |(m_en & m_pd)) begin
      errors++;
      $display("FAIL %s irq act=%b exp=%b", req, irq, |(m_en & m_pd));
    end
  endtask

  task automatic cyc(logic w, logic [31:0] d, logic [3:0] b, logic [NSRC-1:0] s, string req);
    wr = w; wd = d; be = b; src = s;
    @(posedge clk);
    model_step();
    #1;
    wr = 0; src = 0;
    check(req);
  endtask

  initial begin
    #10000000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #12 check("R1");
    rst_n = 1;
    @(negedge clk);
    cyc(1, 32'h0000_0030, 4'hF, 2'b00, "R2");
    cyc(1, 32'hFFFF_FFFF, 4'h0, 2'b00, "R8");
    cyc(0, 0, 0, 2'b01, "R3");
    cyc(1, 32'h0000_0000, 4'hF, 2'b10, "R3");
    cyc(1, 32'h0000_0010, 4'hF, 2'b00, "R9");
    cyc(0, 0, 0, 0, "R6");
    cyc(1, 32'h0020_0010, 4'hF, 2'b00, "R4");
    cyc(1, 32'h0010_0010, 4'h3, 2'b00, "R8");
    cyc(1, 32'h0010_0010, 4'hF, 2'b01, "R5");
    cyc(1, 32'hFFFF_FFCF, 4'hF, 2'b00, "R7");
    cyc(1, 32'hFFFF_0000, 4'hC, 2'b00, "R9");
    for (int n = 0; n < 400; n++) begin
      cyc($urandom_range(0, 1), $urandom, 4'($urandom), 2'($urandom), "R6");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule